// File: doc/BRIEF.md
# I2C EEPROM-style slave memory

This block makes an on-chip byte array answer on an I2C bus the way a small serial EEPROM does. The bus pins are brought into the system clock domain through two-flop synchronisers. Edges of the clock line and start and stop conditions are detected from the synchronised samples. The block drives the data line only through an open-drain pull-down enable.

A master selects the block with a 7-bit device address. The upper four bits of that address come from a parameter and the lower three from pins. In a write transfer, the first byte after the address loads the word pointer and every following byte is stored. In a read transfer, bytes are returned from the current pointer until the master declines one. An active-high protect input can block writes either to the whole array or to its upper half only, chosen by a parameter. The storage is a plain register array cleared at reset.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0, the block is idle and every array byte reads back as 0x00.
- R2: The device address is {DEV_HI, addr_pins}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock pulse. On a mismatch it leaves SDA released and ignores every byte until the next start condition.
- R3: The block changes `sda_oe` only while the synchronised SCL is low, except for releasing it on a start or stop condition.
- R4: In a write, the first byte after the device address sets the word pointer. Its low log2(DEPTH) bits are used, and the higher pointer bits are cleared. Each later byte is stored at the pointer, which then increments and wraps from DEPTH-1 to 0.
- R5: Every byte received after a matching write address, whether it is a word address or data, is acknowledged with SDA low during the ninth pulse.
- R6: In a read, the block shifts out the byte at the current pointer MSB first and increments the pointer after each byte. A read without a preceding word address continues from where the last transfer left the pointer.
- R7: When the master leaves SDA high on the ninth pulse of a read byte (NACK), the block stops driving and releases SDA.
- R8: With WP_UPPER_ONLY = 0 and `wp` = 1, no byte is stored, but data bytes are still acknowledged.
- R9: With WP_UPPER_ONLY = 1 and `wp` = 1, bytes aimed at pointer values with the top pointer bit set (the upper half) are not stored but are acknowledged, and lower-half bytes are stored.
- R10: SDA falling while SCL is high is a start condition and restarts device-address reception from any state, so a repeated start inside a transfer begins a new transfer without losing the pointer.
- R11: SDA rising while SCL is high is a stop condition and returns the block to idle with SDA released.
- R12: DEPTH must be 128, 256, 512 or 1024 bytes. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_pins | input | 3 | Low three bits of the device address |
| wp | input | 1 | Active-high write protect |

## Verification
The bench puts two copies of the block on one shared wired-AND bus. One is 128 bytes deep with the default upper address field, pins 3'b011 and upper-half protection. The other is 256 bytes deep, on pins 3'b101, with whole-array protection. This brings both protect variants, two pointer widths and the wrap at 127 within reach in one run. It also exercises address selection between two live slaves: each device must stay silent while the other is addressed.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WORD,
      ST_DATA,
      ST_RD,
      ST_RACK
   } ee_state_t;

   function automatic bit depth_ok(input int unsigned d);
      return (d == 128) || (d == 256) || (d == 512) || (d == 1024);
   endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0] scl_ff, sda_ff;
   logic       scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= 2'b11;
         sda_ff <= 2'b11;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[0], scl_i};
         sda_ff <= {sda_ff[0], sda_i};
         scl_q  <= scl_ff[1];
         sda_q  <= sda_ff[1];
      end
   end

   assign scl_s     = scl_ff[1];
   assign sda_s     = sda_ff[1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   logic [7:0] arr [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) arr[i] <= 8'h00;
      end else if (we) begin
         arr[addr] <= wdata;
      end
   end

   assign rdata = arr[addr];

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
   import i2c_ee_pkg::*;
#(
   parameter int unsigned DEPTH         = 128,
   parameter logic [3:0]  DEV_HI        = 4'b1010,
   parameter bit          WP_UPPER_ONLY = 1'b0,
   localparam int unsigned AW           = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [2:0]    addr_pins,
   input  logic          wp,
   input  logic [7:0]    rd_data,
   output logic          sda_oe,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata
);
   ee_state_t     state;
   logic [3:0]    cnt;
   logic [7:0]    shreg, txsh;
   logic [AW-1:0] ptr;
   logic          ack_slot, rw, nack, prot;
   logic [6:0]    dev_addr;

   assign dev_addr = {DEV_HI, addr_pins};

   generate
      if (WP_UPPER_ONLY) begin : g_wp_half
         assign prot = wp & ptr[AW-1];
      end else begin : g_wp_all
         assign prot = wp;
      end
   endgenerate

   assign mem_addr  = ptr;
   assign mem_wdata = shreg;
   assign mem_we    = (state == ST_DATA) && scl_fall && (cnt == 4'd8) && !ack_slot && !prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txsh     <= '0;
         ptr      <= '0;
         sda_oe   <= 1'b0;
         ack_slot <= 1'b0;
         rw       <= 1'b0;
         nack     <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         cnt      <= '0;
         ack_slot <= 1'b0;
         sda_oe   <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         ack_slot <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_WORD, ST_DATA: begin
               if (scl_rise && !ack_slot && cnt != 4'd8) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 4'd1;
               end else if (scl_fall && ack_slot) begin
                  ack_slot <= 1'b0;
                  sda_oe   <= 1'b0;
                  cnt      <= '0;
                  if (state == ST_ADDR) begin
                     if (rw) begin
                        state  <= ST_RD;
                        sda_oe <= ~rd_data[7];
                        txsh   <= {rd_data[6:0], 1'b0};
                        ptr    <= ptr + 1'b1;
                     end else begin
                        state <= ST_WORD;
                     end
                  end else if (state == ST_WORD) begin
                     state <= ST_DATA;
                  end
               end else if (scl_fall && cnt == 4'd8) begin
                  if (state == ST_ADDR) begin
                     if (shreg[7:1] == dev_addr) begin
                        ack_slot <= 1'b1;
                        sda_oe   <= 1'b1;
                        rw       <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     ack_slot <= 1'b1;
                     sda_oe   <= 1'b1;
                     if (state == ST_WORD) ptr <= AW'(shreg);
                     else                  ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  cnt <= cnt + 4'd1;
               end else if (scl_fall) begin
                  if (cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else begin
                     sda_oe <= ~txsh[7];
                     txsh   <= {txsh[6:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack <= sda_s;
               end else if (scl_fall) begin
                  if (nack) begin
                     state <= ST_IDLE;
                  end else begin
                     state  <= ST_RD;
                     cnt    <= '0;
                     sda_oe <= ~rd_data[7];
                     txsh   <= {rd_data[6:0], 1'b0};
                     ptr    <= ptr + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   p_oe_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

   p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR) && !sda_oe);

   p_nomatch_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && scl_fall && cnt == 4'd8 && !ack_slot && !start_det && !stop_det
       && shreg[7:1] != dev_addr) |=> !sda_oe && state == ST_IDLE);

   p_bitcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd8);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int unsigned DEPTH         = 128,
   parameter logic [3:0]  DEV_HI        = 4'b1010,
   parameter bit          WP_UPPER_ONLY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] addr_pins,
   input  logic       wp
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (!i2c_ee_pkg::depth_ok(DEPTH)) begin : g_bad_depth_r12
         $error("i2c_eeprom_slave: DEPTH must be 128, 256, 512 or 1024");
      end
   endgenerate

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, rd_data;

   i2c_ee_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_ee_ctrl #(
      .DEPTH         (DEPTH),
      .DEV_HI        (DEV_HI),
      .WP_UPPER_ONLY (WP_UPPER_ONLY)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_pins (addr_pins),
      .wp        (wp),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   i2c_ee_mem #(.DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (rd_data)
   );

   p_wp_all_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && !WP_UPPER_ONLY) |-> !mem_we);

   p_wp_upper_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wp && mem_addr[AW-1]) |-> !mem_we);

endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
   localparam int Q = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic wp_a = 1'b0, wp_b = 1'b0;
   logic oe_a, oe_b;
   wire  sda_bus = sda_m & ~oe_a & ~oe_b;

   i2c_eeprom_slave #(.DEPTH(128), .DEV_HI(4'b1010), .WP_UPPER_ONLY(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(oe_a), .addr_pins(3'b011), .wp(wp_a));

   i2c_eeprom_slave #(.DEPTH(256), .DEV_HI(4'b1010), .WP_UPPER_ONLY(1'b0)) dut_full_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(oe_b), .addr_pins(3'b101), .wp(wp_b));

   logic [7:0] mdl_a [128];
   logic [7:0] mdl_b [256];
   int ptr_a = 0, ptr_b = 0;
   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start;
      sda_m = 1'b1; q; scl_m = 1'b1; q; sda_m = 1'b0; q; scl_m = 1'b0; q;
   endtask

   task automatic i2c_stop;
      scl_m = 1'b0; sda_m = 1'b0; q; scl_m = 1'b1; q; sda_m = 1'b1; q;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; q; scl_m = 1'b1; q; q; scl_m = 1'b0; q;
      end
      sda_m = 1'b1; q; scl_m = 1'b1; q; ack = !sda_bus; q; scl_m = 1'b0; q;
   endtask

   task automatic recv_byte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         q; scl_m = 1'b1; q; b = {b[6:0], sda_bus}; q; scl_m = 1'b0; q;
      end
      sda_m = ~ack; q; scl_m = 1'b1; q; q; scl_m = 1'b0; q; sda_m = 1'b1;
   endtask

   function automatic logic [7:0] dev_byte(input bit dev, input bit rd);
      return dev ? {7'b1010101, rd} : {7'b1010011, rd};
   endfunction

   function automatic bit stored(input bit dev, input int p);
      if (dev) return !wp_b;
      return !(wp_a && p >= 64);
   endfunction

   task automatic write_dev(input bit dev, input int addr, input int n,
                            input logic [7:0] d [8], input string req);
      bit ack;
      int dep = dev ? 256 : 128;
      int p;
      i2c_start;
      send_byte(dev_byte(dev, 1'b0), ack); chk(ack, "R2", ack, 1);
      send_byte(8'(addr), ack);            chk(ack, "R5", ack, 1);
      p = addr % dep;
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], ack);
         chk(ack, req, ack, 1);
         if (stored(dev, p)) begin
            if (dev) mdl_b[p] = d[i]; else mdl_a[p] = d[i];
         end
         p = (p + 1) % dep;
      end
      i2c_stop;
      if (dev) ptr_b = p; else ptr_a = p;
   endtask

   task automatic read_dev(input bit dev, input bit set_addr, input int addr,
                           input int n, input string req);
      bit ack;
      logic [7:0] b, e;
      int dep = dev ? 256 : 128;
      int p = dev ? ptr_b : ptr_a;
      if (set_addr) begin
         i2c_start;
         send_byte(dev_byte(dev, 1'b0), ack); chk(ack, "R2", ack, 1);
         send_byte(8'(addr), ack);            chk(ack, "R4", ack, 1);
         p = addr % dep;
      end
      i2c_start;
      send_byte(dev_byte(dev, 1'b1), ack); chk(ack, "R6", ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         e = dev ? mdl_b[p] : mdl_a[p];
         chk(b == e, req, b, e);
         p = (p + 1) % dep;
      end
      q;
      chk(!oe_a && !oe_b, "R7", {oe_a, oe_b}, 0);
      i2c_stop;
      if (dev) ptr_b = p; else ptr_a = p;
   endtask

   initial begin
      logic [7:0] d [8];
      logic [7:0] b;
      bit ack;
      for (int i = 0; i < 128; i++) mdl_a[i] = 8'h00;
      for (int i = 0; i < 256; i++) mdl_b[i] = 8'h00;
      void'($urandom(32'd4411));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: released after reset
      chk(!oe_a && !oe_b, "R1", {oe_a, oe_b}, 0);
      read_dev(1'b0, 1'b1, 8'h05, 2, "R1");

      // R4/R6: sequential write and read back
      for (int i = 0; i < 8; i++) d[i] = 8'(8'hA0 + i * 7);
      write_dev(1'b0, 8'h10, 4, d, "R5");
      read_dev(1'b0, 1'b1, 8'h10, 4, "R4");
      // R6: current-address read continues from pointer
      read_dev(1'b0, 1'b0, 0, 2, "R6");

      // R4: wrap from 127 to 0; pointer byte's top bit is ignored
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
      write_dev(1'b0, 8'hFE, 3, d, "R4");
      read_dev(1'b0, 1'b1, 8'h7E, 3, "R4");

      // R2: non-matching address is NACKed and following bytes ignored
      i2c_start;
      send_byte(8'hAE, ack); chk(!ack, "R2", ack, 0);
      send_byte(8'h00, ack); chk(!ack, "R2", ack, 0);
      send_byte(8'h99, ack); chk(!ack, "R2", ack, 0);
      i2c_stop;
      read_dev(1'b0, 1'b1, 8'h00, 1, "R2");

      // R9: upper-half protection on the 128-byte device
      wp_a = 1'b1;
      d[0] = 8'h5A; d[1] = 8'h5B; d[2] = 8'h5C; d[3] = 8'h5D;
      write_dev(1'b0, 8'h3E, 4, d, "R9");
      wp_a = 1'b0;
      read_dev(1'b0, 1'b1, 8'h3E, 4, "R9");

      // R8: whole-array protection on the 256-byte device
      wp_b = 1'b1;
      d[0] = 8'hC3; d[1] = 8'h3C;
      write_dev(1'b1, 8'h05, 2, d, "R8");
      wp_b = 1'b0;
      read_dev(1'b1, 1'b1, 8'h05, 2, "R8");
      // R12: full 8-bit pointer on the 256-byte device
      d[0] = 8'hE1; d[1] = 8'hE2;
      write_dev(1'b1, 8'hF0, 2, d, "R12");
      read_dev(1'b1, 1'b1, 8'hF0, 2, "R12");

      // R10: repeated start mid-write keeps the pointer
      i2c_start;
      send_byte(8'hA6, ack); chk(ack, "R10", ack, 1);
      send_byte(8'h20, ack); chk(ack, "R10", ack, 1);
      send_byte(8'h55, ack); chk(ack, "R10", ack, 1);
      mdl_a[8'h20] = 8'h55;
      i2c_start;
      send_byte(8'hA7, ack); chk(ack, "R10", ack, 1);
      recv_byte(1'b0, b); chk(b == mdl_a[8'h21], "R10", b, mdl_a[8'h21]);
      i2c_stop;
      ptr_a = 8'h22;

      // R11: stop right after address returns to idle, released
      i2c_start;
      send_byte(8'hA6, ack); chk(ack, "R11", ack, 1);
      i2c_stop;
      q;
      chk(!oe_a && !oe_b, "R11", {oe_a, oe_b}, 0);
      // R3: read data held stable through the SCL-high window
      read_dev(1'b0, 1'b1, 8'h20, 1, "R3");

      // random mix
      for (int it = 0; it < 24; it++) begin
         bit dev = 1'($urandom_range(0, 1));
         int n   = int'($urandom_range(1, 4));
         int ad  = int'($urandom_range(0, 255));
         if (dev) wp_b = 1'($urandom_range(0, 3) == 0);
         else     wp_a = 1'($urandom_range(0, 2) == 0);
         for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
         write_dev(dev, ad, n, d, dev ? "R8" : "R9");
         wp_a = 1'b0; wp_b = 1'b0;
         read_dev(dev, 1'b1, ad, n, "R4");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule